// File: doc/BRIEF.md
# Receive Byte Buffer

This block is the receive datapath of a two-wire serial controller. A bit-level front end, which handles line sampling, start and stop conditions and acknowledge, presents one sampled data bit per valid strobe. The buffer assembles eight strobed bits into a byte in a shift register. It then hands each finished byte to a holding register that the processor drains through a valid/ready output port.

If a byte completes while the holding register still holds an unread byte, the new byte is not copied. It stays parked in the shift register and the overrun flag rises. Bits that keep arriving shift on top of the parked byte, so the parked value changes. Once the processor reads the held byte, whatever the shift register then contains moves into the holding register on the following cycle.

Back-pressure: the bit input has no ready signal, because a serial line cannot be stalled. A strobe is always consumed. The output port follows valid/ready rules: `byte_valid` stays high and `byte_data` stays stable until a cycle in which `byte_ready` is also high. `byte_ready` has no effect while `byte_valid` is low. `rst_n` is the module reset.

Top module: `rx_byte_buffer`

## Requirements
- R1: While and after `rst_n` is low, `byte_valid` = 0, `overrun` = 0 and `byte_data` = 0, and the bit count restarts at zero (the next eight strobes form a full byte).
- R2: The buffer shifts a bit only on a cycle with `bit_vld` = 1. The first bit strobed becomes the most significant bit (bit 7). The eighth strobe completes the byte.
- R3: When a byte completes and the holding register is empty, `byte_data` shows the byte and `byte_valid` is 1 from the cycle after the eighth strobe.
- R4: A read is a clock edge with `byte_valid` = 1 and `byte_ready` = 1. After a read, `byte_valid` drops unless a byte is loaded on the same edge. `byte_ready` while `byte_valid` = 0 is ignored.
- R5: A byte that completes while the holding register is full and not being read sets `overrun` = 1 and leaves `byte_data` unchanged.
- R6: While a byte is parked, further strobed bits keep shifting into the shift register and overwrite the parked byte. The bit count continues across the park.
- R7: A read clears `overrun` on the same edge.
- R8: After a read with a byte parked, `byte_valid` is 0 for one cycle. On the next cycle it is 1, with the shift register's contents at that time on `byte_data`.
- R9: A byte that completes on the same edge as a read goes straight into the holding register. `byte_valid` stays 1 and `overrun` stays 0.
- R10: While `byte_valid` = 1 and no read occurs, `byte_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low module reset |
| bit_vld | input | 1 | Strobe: a sampled data bit is present |
| bit_val | input | 1 | Sampled data bit |
| byte_data | output | DATA_W | Holding register contents |
| byte_valid | output | 1 | Holding register holds an unread byte |
| byte_ready | input | 1 | Processor takes the held byte |
| overrun | output | 1 | A completed byte is waiting behind an unread one |

## Verification
The bound checker covers the handshake rules on every cycle. These are: `byte_data` holds while a byte waits unread, and `overrun` is high only while `byte_valid` is high. `overrun` rises only on an edge where the held byte was valid and unread. A read clears it, and `byte_valid` falls only after a read. The values those rules cannot pin down come only from the bench's scenarios. These include the MSB-first byte values, the overwritten contents of a parked byte and the one-cycle bubble before it is delivered. They also cover the direct load when a byte completes during a read, and the bit count restarting after a reset taken in the middle of a byte.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  // Source selected for a holding-register load on the current edge.
  typedef enum logic [1:0] {
    LD_NONE   = 2'd0,
    LD_NEW    = 2'd1,  // byte completing this cycle
    LD_PARKED = 2'd2   // byte waiting in the shift register
  } ld_src_e;
endpackage

// File: rtl/rxb_shifter.sv
module rxb_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  output logic [DATA_W-1:0] shreg,
  output logic              done,
  output logic [DATA_W-1:0] next_byte
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt;

  // MSB first: the oldest bit ends up at the top after DATA_W shifts.
  assign next_byte = {shreg[DATA_W-2:0], bit_val};
  assign done      = bit_vld && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (bit_vld) begin
      shreg <= next_byte;
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxb_ctl.sv
module rxb_ctl
  import rxb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    done,
  input  logic    held,
  input  logic    accept,
  output ld_src_e ld_src,
  output logic    overrun
);
  logic parked;
  logic hold_free;
  logic park_now;

  // The holding register can take a byte if empty or being read now.
  assign hold_free = !held || accept;
  assign park_now  = done && !hold_free;

  always_comb begin
    ld_src = LD_NONE;
    if (done && hold_free)     ld_src = LD_NEW;
    else if (parked && !held)  ld_src = LD_PARKED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (park_now)               parked <= 1'b1;
      else if (ld_src != LD_NONE) parked <= 1'b0;

      if (park_now)    overrun <= 1'b1;
      else if (accept) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rxb_hold.sv
module rxb_hold
  import rxb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ld_src_e           ld_src,
  input  logic [DATA_W-1:0] next_byte,
  input  logic [DATA_W-1:0] shreg,
  input  logic              accept,
  output logic [DATA_W-1:0] hold_q,
  output logic              held
);
  logic [DATA_W-1:0] ld_data;

  always_comb begin
    unique case (ld_src)
      LD_NEW:    ld_data = next_byte;
      LD_PARKED: ld_data = shreg;
      default:   ld_data = hold_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      held   <= 1'b0;
    end else if (ld_src != LD_NONE) begin
      hold_q <= ld_data;
      held   <= 1'b1;
    end else if (accept) begin
      held   <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_byte_buffer.sv
module rx_byte_buffer
  import rxb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_valid,
  input  logic              byte_ready,
  output logic              overrun
);
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] next_byte;
  logic              done;
  logic              accept;
  ld_src_e           ld_src;

  assign accept = byte_valid && byte_ready;

  rxb_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .shreg(shreg), .done(done), .next_byte(next_byte)
  );

  rxb_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .done(done), .held(byte_valid),
    .accept(accept), .ld_src(ld_src), .overrun(overrun)
  );

  rxb_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .ld_src(ld_src), .next_byte(next_byte),
    .shreg(shreg), .accept(accept), .hold_q(byte_data), .held(byte_valid)
  );
endmodule

// File: rtl/rx_byte_buffer_chk.sv
module rx_byte_buffer_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] byte_data,
  input logic              byte_valid,
  input logic              byte_ready,
  input logic              overrun
);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready) |=> $stable(byte_data));

  assert_ovr_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> byte_valid);

  assert_ovr_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(byte_valid && !byte_ready));

  assert_read_clears_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ready) |=> !overrun);

  assert_valid_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(byte_valid) |-> $past(byte_ready));
endmodule

bind rx_byte_buffer rx_byte_buffer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_data(byte_data), .byte_valid(byte_valid),
  .byte_ready(byte_ready), .overrun(overrun)
);

// File: tb/rx_byte_buffer_test.sv
`timescale 1ns/100ps
module rx_byte_buffer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_vld = 1'b0;
  logic       bit_val = 1'b0;
  logic       byte_ready = 1'b0;
  logic [7:0] byte_data;
  logic       byte_valid;
  logic       overrun;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  rx_byte_buffer #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                     input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: MSB-first bits, optional idle cycle between strobes.
  task automatic send_bits(input logic [7:0] v, input int n, input bit gap);
    for (int i = n - 1; i >= 0; i--) begin
      bit_vld = 1'b1;
      bit_val = v[i];
      @(negedge clk);
      bit_vld = 1'b0;
      if (gap) @(negedge clk);
    end
    bit_vld = 1'b0;
    #1;
  endtask

  // Driver: push the expected byte to the scoreboard, then read it.
  task automatic do_read(input logic [7:0] exp);
    exp_q.push_back(exp);
    byte_ready = 1'b1;
    @(negedge clk);
    byte_ready = 1'b0;
    #1;
  endtask

  // Monitor: every accepted read pops and compares one expected byte.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && byte_valid && byte_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected read", byte_data, 8'h00);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(byte_data == e, "R2/R3 read data", byte_data, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    chk(1'b0, "watchdog", 8'h00, 8'h01);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!byte_valid && !overrun && byte_data == 8'h00, "R1 reset state",
        {6'd0, byte_valid, overrun}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // Plain byte, MSB first.
    send_bits(8'hA5, 8, 1'b0);
    chk(byte_valid == 1'b1, "R3 valid after byte", {7'd0, byte_valid}, 8'h01);
    chk(byte_data == 8'hA5, "R2 msb-first value", byte_data, 8'hA5);
    do_read(8'hA5);
    chk(byte_valid == 1'b0, "R4 valid drops after read", {7'd0, byte_valid}, 8'h00);

    // Strobes with gaps between them.
    send_bits(8'h6C, 8, 1'b1);
    chk(byte_data == 8'h6C && byte_valid, "R2 gapped strobes", byte_data, 8'h6C);
    do_read(8'h6C);

    // Overrun and parking.
    send_bits(8'h3C, 8, 1'b0);
    send_bits(8'h81, 8, 1'b0);
    chk(overrun == 1'b1, "R5 overrun set", {7'd0, overrun}, 8'h01);
    chk(byte_data == 8'h3C, "R5 held byte kept", byte_data, 8'h3C);
    send_bits(8'h0A, 4, 1'b0);  // overwrites the parked byte
    chk(byte_data == 8'h3C && byte_valid, "R10 held stable", byte_data, 8'h3C);
    do_read(8'h3C);
    chk(overrun == 1'b0, "R7 overrun cleared", {7'd0, overrun}, 8'h00);
    chk(byte_valid == 1'b0, "R8 bubble cycle", {7'd0, byte_valid}, 8'h00);
    @(negedge clk);
    #1;
    chk(byte_valid == 1'b1, "R8 parked delivered", {7'd0, byte_valid}, 8'h01);
    chk(byte_data == 8'h1A, "R6 overwritten parked value", byte_data, 8'h1A);
    do_read(8'h1A);
    send_bits(8'h06, 4, 1'b0);  // count continued across the park
    chk(byte_valid && byte_data == 8'hA6, "R6 count continues", byte_data, 8'hA6);
    do_read(8'hA6);

    // Ready while empty is ignored.
    byte_ready = 1'b1;
    @(negedge clk);
    byte_ready = 1'b0;
    #1;
    chk(!byte_valid && !overrun, "R4 ready while empty",
        {6'd0, byte_valid, overrun}, 8'h00);

    // Completion on the same edge as a read.
    send_bits(8'h55, 8, 1'b0);
    send_bits(8'h78, 7, 1'b0);  // top seven bits of 0xF0
    exp_q.push_back(8'h55);
    bit_vld = 1'b1;
    bit_val = 1'b0;
    byte_ready = 1'b1;
    @(negedge clk);
    bit_vld = 1'b0;
    byte_ready = 1'b0;
    #1;
    chk(byte_valid && byte_data == 8'hF0, "R9 direct load on read", byte_data, 8'hF0);
    chk(overrun == 1'b0, "R9 no overrun", {7'd0, overrun}, 8'h00);
    do_read(8'hF0);

    // Reset during overrun and mid-byte.
    send_bits(8'h11, 8, 1'b0);
    send_bits(8'h22, 8, 1'b0);
    send_bits(8'h05, 3, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    chk(!byte_valid && !overrun && byte_data == 8'h00, "R1 reset clears",
        {6'd0, byte_valid, overrun}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    send_bits(8'h7E, 8, 1'b0);
    chk(byte_valid && byte_data == 8'h7E, "R1 count restarted", byte_data, 8'h7E);
    do_read(8'h7E);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule